// File: doc/BRIEF.md
# Replay-Capable Synchronous FIFO

This block is a single-clock first-in first-out buffer whose read position can be saved and later restored, so that a stretch of data can be sent again without the producer writing it a second time. A consumer raises the mark input while the oldest unread word is the one it may need to replay. If the downstream link later reports an error, the consumer pulls the active-low retransmit input low, and reading resumes from the saved word.

Two read-timing modes are latched at full reset. In standard mode a word leaves storage only when a read is requested, and the two flags report empty and full. In fall-through mode the oldest word is presented on the output on its own, and the flags report output-valid and space-available. A half-full flag works in both modes. A full reset clears the contents and takes a new timing mode. A partial reset clears the contents but keeps the mode already in force.

Top module: `mark_fifo`

## Requirements
- R1: After a full reset (rstFullN low at a clock edge) the buffer holds no words, rdData is 0, halfFull is 0, and the mode is taken from modeSel (1 = fall-through, 0 = standard). In standard mode outFlag=1 and inFlag=0. In fall-through mode outFlag=0 and inFlag=1.
- R2: A partial reset (rstPartN low, rstFullN high) empties the buffer and clears rdData, and leaves the timing mode unchanged whatever modeSel is.
- R3: In standard mode a clock edge with wrEnN low and the buffer not full stores wrData. An edge with rdEnN low and the buffer not empty puts the oldest stored word on rdData after that edge. Otherwise rdData holds its value.
- R4: In standard mode outFlag is 1 exactly when zero words are stored, and inFlag is 1 exactly when DEPTH words are stored.
- R5: In fall-through mode, a word written at edge N into an empty buffer appears on rdData with outFlag=1 after edge N+1, with no read request. An edge with rdEnN low consumes the presented word and presents the next one if there is one.
- R6: In fall-through mode outFlag is 1 exactly when rdData holds a valid unread word, and inFlag is 1 exactly when fewer than DEPTH words are held (the presented word counts as held).
- R7: halfFull is 1 exactly when more than DEPTH/2 words are held, in both modes.
- R8: A write while full and a read while empty are ignored. No word is lost, duplicated or reordered, and the flags do not change because of them.
- R9: markIn high at an edge with rtN high saves the position of the oldest unread word: in standard mode the word the next read would return, in fall-through mode the word on rdData.
- R10: rtN low at an edge returns the read position to the saved mark, so that later reads replay from the marked word. The held-word count, and so every flag, is recomputed from the restored position. A read or mark request on the same edge is ignored.
- R11: After a retransmit, the replayed words count as held, and a write is refused once DEPTH words are held.
- R12: Either reset sets the saved mark to the first location, so a retransmit after a reset replays from the first word written after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstFullN | input | 1 | Full reset, active low, synchronous; latches modeSel |
| rstPartN | input | 1 | Partial reset, active low, synchronous; keeps mode |
| modeSel | input | 1 | Timing mode sampled at full reset: 1 fall-through, 0 standard |
| wrEnN | input | 1 | Write enable, active low |
| wrData | input | DATA_W | Write data |
| rdEnN | input | 1 | Read enable, active low |
| markIn | input | 1 | Save the current read position, active high |
| rtN | input | 1 | Retransmit from mark, active low |
| rdData | output | DATA_W | Read data register |
| outFlag | output | 1 | Standard: empty; fall-through: output valid |
| inFlag | output | 1 | Standard: full; fall-through: space available |
| halfFull | output | 1 | More than DEPTH/2 words held |

## Verification
The bench compares every cycle against a behavioural model that keeps a history of written words indexed by count, so a replay is checked word by word against the values first written. Directed runs in both modes push the buffer past full and past empty: a design that moved a pointer on a refused access would return a duplicate or skip a word. Retransmit is driven together with a read, so a design that let the read win would present the word after the mark instead of the mark itself. A long random run in each mode mixes marks and retransmits. Here a design that left replayed words out of the count would overwrite them, and the replayed data would not match. Partial resets with modeSel flipped expose a design that re-latched the mode or kept a stale mark.

// File: rtl/mark_fifo_pkg.sv
package mark_fifo_pkg;
  // Strobes sent from the control to the storage/output datapath.
  typedef struct packed {
    logic wrStb;    // store wrData at wrAddr
    logic rdStb;    // load rdData from rdAddr
    logic clrData;  // clear rdData (either reset)
  } memStrobe_t;
endpackage

// File: rtl/mark_fifo_dpath.sv
module mark_fifo_dpath
  import mark_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.clrData)    rdData <= '0;
    else if (strobe.rdStb) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/mark_fifo_ctrl.sv
module mark_fifo_ctrl
  import mark_fifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstFullN,
  input  logic              rstPartN,
  input  logic              modeSel,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic              markIn,
  input  logic              rtN,
  output logic              outFlag,
  output logic              inFlag,
  output logic              halfFull,
  output memStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_CNT = PTR_W'(DEPTH / 2);

  logic             fwftMode;
  logic             outValid;
  logic [PTR_W-1:0] wrPtr, rdPtr, markPtr;
  logic [PTR_W-1:0] headPtr, used;
  logic             anyRst, isFull, isEmpty, memHas;
  logic             wrOk, rtGo, rdReq, fetch, drop;

  always_comb begin
    anyRst  = !rstFullN || !rstPartN;
    headPtr = rdPtr - PTR_W'(fwftMode & outValid);
    used    = wrPtr - headPtr;
    isFull  = (used == FULL_CNT);
    isEmpty = (used == '0);
    memHas  = (wrPtr != rdPtr);
    rtGo    = !rtN;
    rdReq   = !rdEnN;
    wrOk    = !wrEnN && !isFull;
    if (fwftMode) begin
      fetch = !rtGo && memHas && (!outValid || rdReq);
      drop  = rtGo || (rdReq && outValid && !memHas);
    end else begin
      fetch = !rtGo && rdReq && !isEmpty;
      drop  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (anyRst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      markPtr  <= '0;
      outValid <= 1'b0;
      if (!rstFullN) fwftMode <= modeSel;
    end else begin
      if (wrOk) wrPtr <= wrPtr + 1'b1;
      if (rtGo)       rdPtr <= markPtr;
      else if (fetch) rdPtr <= rdPtr + 1'b1;
      if (markIn && !rtGo) markPtr <= headPtr;
      if (fetch && fwftMode) outValid <= 1'b1;
      else if (drop)         outValid <= 1'b0;
    end
  end

  always_comb begin
    strobe.wrStb   = wrOk && !anyRst;
    strobe.rdStb   = fetch && !anyRst;
    strobe.clrData = anyRst;
    wrAddr         = wrPtr[ADDR_W-1:0];
    rdAddr         = rdPtr[ADDR_W-1:0];
    outFlag        = fwftMode ? outValid : isEmpty;
    inFlag         = fwftMode ? !isFull : isFull;
    halfFull       = (used > HALF_CNT);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (anyRst)
    used <= FULL_CNT); // R11
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (anyRst)
    (isFull && !wrEnN) |=> $stable(wrPtr)); // R8
  AST_RT_RESTORE: assert property (@(posedge clk) disable iff (anyRst)
    !rtN |=> (rdPtr == $past(markPtr))); // R10
  AST_MARK_SAVE: assert property (@(posedge clk) disable iff (anyRst)
    (markIn && rtN) |=> (markPtr == $past(headPtr))); // R9
  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rstFullN)
    !rstPartN |=> $stable(fwftMode)); // R2
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (anyRst)
    (fwftMode && !outValid && memHas && rtN) |=> outValid); // R5
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo
  import mark_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstFullN,
  input  logic              rstPartN,
  input  logic              modeSel,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnN,
  input  logic              markIn,
  input  logic              rtN,
  output logic [DATA_W-1:0] rdData,
  output logic              outFlag,
  output logic              inFlag,
  output logic              halfFull
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  memStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  mark_fifo_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstFullN(rstFullN), .rstPartN(rstPartN), .modeSel(modeSel),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .markIn(markIn), .rtN(rtN),
    .outFlag(outFlag), .inFlag(inFlag), .halfFull(halfFull),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  mark_fifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/sim_mark_fifo.sv
`timescale 1ns/1ps
module sim_mark_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstFullN = 1'b0, rstPartN = 1'b1, modeSel = 1'b0;
  logic wrEnN = 1'b1, rdEnN = 1'b1, markIn = 1'b0, rtN = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic outFlag, inFlag, halfFull;

  always #2.5 clk = ~clk;

  mark_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstFullN(rstFullN), .rstPartN(rstPartN), .modeSel(modeSel),
    .wrEnN(wrEnN), .wrData(wrData), .rdEnN(rdEnN), .markIn(markIn), .rtN(rtN),
    .rdData(rdData), .outFlag(outFlag), .inFlag(inFlag), .halfFull(halfFull)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  // Behavioural model: history of written words by running index.
  logic [DW-1:0] hist [256];
  int  wrIdx, head, mark;
  bit  pv, fwft;
  logic [DW-1:0] lastData;

  function automatic void modelReset(bit full, bit ms);
    wrIdx = 0; head = 0; mark = 0; pv = 0; lastData = '0;
    if (full) fwft = ms;
  endfunction

  task automatic checkOut(string tag);
    int used;
    bit eo, ei, eh;
    used = wrIdx - head;
    eo = fwft ? pv : (used == 0);
    ei = fwft ? (used < DEPTH) : (used == DEPTH);
    eh = (used > DEPTH / 2);
    compared++;
    if (rdData !== lastData || outFlag !== eo || inFlag !== ei || halfFull !== eh) begin
      mismatched++;
      $display("FAIL %s: got data=%h out=%b in=%b half=%b, expected data=%h out=%b in=%b half=%b",
               tag, rdData, outFlag, inFlag, halfFull, lastData, eo, ei, eh);
    end
  endtask

  task automatic doReset(bit full, bit ms, string tag);
    @(negedge clk);
    rstFullN = !full; rstPartN = full; modeSel = ms;
    wrEnN = 1; rdEnN = 1; markIn = 0; rtN = 1;
    @(posedge clk); #1;
    modelReset(full, ms);
    rstFullN = 1; rstPartN = 1;
    checkOut(tag);
  endtask

  task automatic cyc(bit wn, logic [DW-1:0] wd, bit rn, bit mk, bit rtn, string tag);
    int used;
    bit rt, wrOk, pvOld, memHas;
    int headOld;
    @(negedge clk);
    wrEnN = wn; wrData = wd; rdEnN = rn; markIn = mk; rtN = rtn;
    used = wrIdx - head;
    rt = !rtn;
    wrOk = !wn && used < DEPTH;
    headOld = head; pvOld = pv;
    if (rt) begin
      head = mark; pv = 0;
    end else if (!fwft) begin
      if (!rn && used > 0) begin lastData = hist[head % 256]; head++; end
    end else begin
      memHas = wrIdx > head + int'(pvOld);
      if (pvOld && !rn) begin head++; pv = 0; end
      if ((!pvOld || !rn) && memHas) begin pv = 1; lastData = hist[head % 256]; end
    end
    if (mk && !rt) mark = headOld;
    if (wrOk) begin hist[wrIdx % 256] = wd; wrIdx++; end
    @(posedge clk); #1;
    wrEnN = 1; rdEnN = 1; markIn = 0; rtN = 1;
    checkOut(tag);
  endtask

  task automatic directed(bit m);
    doReset(1, m, "R1");
    // fill past full
    for (int i = 0; i < DEPTH + 3; i++)
      cyc(0, 8'h10 + 8'(i), 1, 0, 1, (i >= DEPTH) ? "R8" : (m ? "R6" : "R4"));
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 1, "R7");
    // drain past empty
    for (int i = 0; i < DEPTH + 3; i++)
      cyc(1, 0, 0, 0, 1, (i >= DEPTH) ? "R8" : (m ? "R5" : "R3"));
    // mark then replay, retransmit together with a read
    for (int i = 0; i < 5; i++) cyc(0, 8'h40 + 8'(i), 1, 0, 1, m ? "R5" : "R3");
    cyc(1, 0, 0, 0, 1, "R3");
    cyc(1, 0, 0, 1, 1, "R9");
    cyc(1, 0, 0, 0, 1, "R9");
    cyc(1, 0, 0, 0, 1, "R9");
    cyc(1, 0, 0, 1, 0, "R10");
    cyc(1, 0, 1, 0, 1, "R10");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 1, "R10");
    // after retransmit, writes stop at DEPTH held words
    cyc(1, 0, 1, 0, 0, "R10");
    for (int i = 0; i < DEPTH; i++) cyc(0, 8'h60 + 8'(i), 1, 0, 1, "R11");
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 0, 0, 0, 1, "R11");
    // partial reset with modeSel flipped; mark back to first word
    cyc(0, 8'h70, 1, 1, 1, "R9");
    doReset(0, !m, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 8'h80 + 8'(i), 1, 0, 1, "R2");
    cyc(1, 0, 0, 0, 1, "R12");
    cyc(1, 0, 0, 0, 1, "R12");
    cyc(1, 0, 1, 0, 0, "R12");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 1, "R12");
  endtask

  task automatic randomRun(bit m, int n);
    doReset(1, m, "R1");
    for (int k = 0; k < n; k++) begin
      int unsigned r;
      bit wn, rn, mk, rtn;
      int used;
      r = $urandom();
      used = wrIdx - head;
      wn = (r[1:0] == 2'b00);
      rn = (r[3:2] == 2'b00);
      mk = (r[6:4] == 3'b000);
      rtn = !(r[10:7] == 4'b0000);
      if (!wn && (wrIdx - mark >= DEPTH) && used < DEPTH) wn = 1;
      cyc(wn, r[23:16], rn, mk, rtn, m ? "R6" : "R10");
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    directed(0);
    directed(1);
    randomRun(0, 3000);
    randomRun(1, 3000);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule